// File: doc/BRIEF.md
# Any-Type Variable-Latency Execute Stage

This block is the execute stage of an out-of-order core. It holds WIDTH identical, fully pipelined function units, and each unit can run every operation type. Every cycle it takes an issue bundle of up to WIDTH instructions. Each instruction carries a ROB tag, a flag saying whether it writes a destination, and a 2-bit operation type. The operation type alone sets how long the instruction stays in execute.

Each accepted instruction is placed into a timing pipeline, at the depth that matches its latency. It then moves one step toward the exit on every clock. When it reaches the exit, it shows up in the completion bundle, which is WIDTH entries wide. If the instruction writes a destination, its tag is also driven on the wakeup bundle in the same cycle, so that waiting queue entries can mark the operand ready. Instructions finish out of order, and several can finish together, even when they were issued in different cycles. The issue side must not send more instructions due in one cycle than the completion bundle can carry. Given that, no instruction ever waits, and the stage never stalls.

Top module: `anyop_exec_stage`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every bit of doneValid and wakeValid is 0.
- R2: A slot with issueValid=1 and op code 0 that is presented in cycle k appears exactly once on the completion bundle, with its tag, in cycle k+1.
- R3: A slot with issueValid=1 and op code 1 that is presented in cycle k completes exactly once, in cycle k+2.
- R4: A slot with issueValid=1 and op code 2 that is presented in cycle k completes exactly once, in cycle k+5.
- R5: Op code 3 is reserved. A slot with issueValid=1 and op code 3 is dropped and never shows up on the completion or wakeup bundles.
- R6: Every legal slot of every bundle completes, with no loss, including when full-width bundles arrive back to back with no idle cycle between them.
- R7: In each cycle, the number of set doneValid bits equals the number of instructions due that cycle, for any mix of issue cycles and latencies, up to WIDTH.
- R8: wakeValid[c] is 1 exactly when doneValid[c] is 1 and that instruction had issueDstValid=1. When it is 1, wakeTag[c] equals doneTag[c].
- R9: A slot with issueValid=0 is ignored, whatever its op code, tag and destination flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | WIDTH | Per-slot valid bit of the issue bundle |
| issueOp | input | WIDTH x 2 | Per-slot operation type (0, 1 and 2 are legal; 3 is reserved) |
| issueTag | input | WIDTH x TAG_W | Per-slot ROB tag |
| issueDstValid | input | WIDTH | Per-slot flag: the instruction writes a destination |
| doneValid | output | WIDTH | Completion bundle valid bits |
| doneTag | output | WIDTH x TAG_W | Completion bundle ROB tags |
| wakeValid | output | WIDTH | Wakeup broadcast valid bits |
| wakeTag | output | WIDTH x TAG_W | Wakeup broadcast tags |

## Verification
The assertions take for granted that the issue side never sends more than WIDTH instructions that all become due in the same cycle. Under that rule, every legal slot finds a free column in its row, and no entry is ever dropped. The stimulus keeps to the rule through a per-cycle count of pending completions. Any legal slot that would push its due cycle above WIDTH is sent with its valid bit cleared, so the sweeps and the pseudo-random stream stay inside the contract. Slots that are invalid or reserved get tags from a range that live instructions never use, so if one of them leaks out it is seen at once.

// File: rtl/anyop_exec_pkg.sv
`timescale 1ns/1ps
package anyop_exec_pkg;

  // Width of the slot index carried in a cell strobe (supports up to 16 slots).
  localparam int SLOT_IDX_W = 4;

  typedef enum logic [1:0] {
    OP_SHORT = 2'd0,
    OP_MID   = 2'd1,
    OP_LONG  = 2'd2,
    OP_RSVD  = 2'd3
  } opClass_t;

  // Control to datapath: load one timing cell from a chosen issue slot.
  typedef struct packed {
    logic                  load;
    logic [SLOT_IDX_W-1:0] src;
  } cellStrobe_t;

endpackage

// File: rtl/anyop_exec_ctrl.sv
`timescale 1ns/1ps
module anyop_exec_ctrl
  import anyop_exec_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int LAT_SHORT = 1,
  parameter int LAT_MID   = 2,
  parameter int LAT_LONG  = 5,
  parameter int DEPTH     = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [WIDTH-1:0]                  issueValid,
  input  logic [WIDTH-1:0][1:0]             issueOp,
  input  logic [DEPTH-1:0][WIDTH-1:0]       rowOcc,
  output cellStrobe_t [DEPTH-1:0][WIDTH-1:0] strobe
);

  localparam int ROW_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CELL_N = DEPTH * WIDTH;

  function automatic int latOf(input logic [1:0] op);
    case (opClass_t'(op))
      OP_SHORT: return LAT_SHORT;
      OP_MID:   return LAT_MID;
      OP_LONG:  return LAT_LONG;
      default:  return 0;
    endcase
  endfunction

  logic [WIDTH-1:0]            legal;
  logic [DEPTH-1:0][WIDTH-1:0] freeCol;
  logic [DEPTH-1:0][WIDTH-1:0] avail;
  logic [ROW_W-1:0]            row;
  logic                        placed;
  logic [CELL_N-1:0]           loadFlat;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      legal[i] = issueValid[i] && (latOf(issueOp[i]) != 0);
    end
  end

  // A column of row d is free when nothing shifts into it from row d+1.
  for (genvar d = 0; d < DEPTH; d++) begin : g_free
    if (d == DEPTH - 1) begin : g_top
      assign freeCol[d] = '1;
    end else begin : g_mid
      assign freeCol[d] = ~rowOcc[d+1];
    end
  end

  // In slot order, each legal slot takes the lowest free column of its row.
  always_comb begin
    strobe = '0;
    avail  = freeCol;
    row    = '0;
    placed = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (legal[i]) begin
        row    = ROW_W'(latOf(issueOp[i]) - 1);
        placed = 1'b0;
        for (int c = 0; c < WIDTH; c++) begin
          if (!placed && avail[row][c]) begin
            strobe[row][c].load = 1'b1;
            strobe[row][c].src  = SLOT_IDX_W'(i);
            avail[row][c]       = 1'b0;
            placed              = 1'b1;
          end
        end
      end
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_flat_r
    for (genvar c = 0; c < WIDTH; c++) begin : g_flat_c
      assign loadFlat[d*WIDTH+c] = strobe[d][c].load;
    end
  end

  AST_ALL_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    $countones(loadFlat) == $countones(legal)) else $error("legal slot not placed"); // R6

  for (genvar d = 0; d < DEPTH; d++) begin : g_chk_r
    for (genvar c = 0; c < WIDTH; c++) begin : g_chk_c
      for (genvar i = 0; i < WIDTH; i++) begin : g_chk_s
        AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
          (strobe[d][c].load && strobe[d][c].src == SLOT_IDX_W'(i)) |->
          (issueValid[i] && issueOp[i] != OP_RSVD)) else $error("illegal slot loaded"); // R5 R9
        AST_ROW_MATCHES_TYPE: assert property (@(posedge clk) disable iff (rst)
          (strobe[d][c].load && strobe[d][c].src == SLOT_IDX_W'(i)) |->
          (latOf(issueOp[i]) == d + 1)) else $error("wrong entry depth"); // R2 R3 R4
      end
    end
  end

endmodule

// File: rtl/anyop_exec_datapath.sv
`timescale 1ns/1ps
module anyop_exec_datapath
  import anyop_exec_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TAG_W = 6,
  parameter int DEPTH = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [WIDTH-1:0][TAG_W-1:0]        issueTag,
  input  logic [WIDTH-1:0]                   issueDstValid,
  input  cellStrobe_t [DEPTH-1:0][WIDTH-1:0] strobe,
  output logic [DEPTH-1:0][WIDTH-1:0]        rowOcc,
  output logic [WIDTH-1:0]                   doneValid,
  output logic [WIDTH-1:0][TAG_W-1:0]        doneTag,
  output logic [WIDTH-1:0]                   wakeValid,
  output logic [WIDTH-1:0][TAG_W-1:0]        wakeTag
);

  logic [DEPTH-1:0][WIDTH-1:0]            cellValid;
  logic [DEPTH-1:0][WIDTH-1:0]            cellDst;
  logic [DEPTH-1:0][WIDTH-1:0][TAG_W-1:0] cellTag;

  for (genvar d = 0; d < DEPTH; d++) begin : g_row
    for (genvar c = 0; c < WIDTH; c++) begin : g_col
      logic             vQ, dQ, vD, dD;
      logic [TAG_W-1:0] tQ, tD, pickTag;
      logic             pickDst;
      logic             upV, upD;
      logic [TAG_W-1:0] upT;

      if (d == DEPTH - 1) begin : g_top
        assign upV = 1'b0;
        assign upD = 1'b0;
        assign upT = '0;
      end else begin : g_mid
        assign upV = cellValid[d+1][c];
        assign upD = cellDst[d+1][c];
        assign upT = cellTag[d+1][c];
      end

      always_comb begin
        pickTag = '0;
        pickDst = 1'b0;
        for (int s = 0; s < WIDTH; s++) begin
          if (strobe[d][c].src == SLOT_IDX_W'(s)) begin
            pickTag = issueTag[s];
            pickDst = issueDstValid[s];
          end
        end
      end

      always_comb begin
        if (strobe[d][c].load) begin
          vD = 1'b1;
          dD = pickDst;
          tD = pickTag;
        end else begin
          vD = upV;
          dD = upD;
          tD = upT;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          vQ <= 1'b0;
          dQ <= 1'b0;
          tQ <= '0;
        end else begin
          vQ <= vD;
          dQ <= dD;
          tQ <= tD;
        end
      end

      assign cellValid[d][c] = vQ;
      assign cellDst[d][c]   = dQ;
      assign cellTag[d][c]   = tQ;

      if (d < DEPTH - 1) begin : g_ovf
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
          strobe[d][c].load |-> !cellValid[d+1][c]) else $error("cell collision"); // R7
      end
      if (d > 0) begin : g_adv
        AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
          cellValid[d][c] |=> (cellValid[d-1][c] && cellTag[d-1][c] == $past(cellTag[d][c])))
          else $error("entry lost in flight"); // R4
      end
      AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        strobe[d][c].load |=> cellValid[d][c]) else $error("load missed"); // R6
    end
  end

  assign rowOcc    = cellValid;
  assign doneValid = cellValid[0];
  assign wakeValid = cellValid[0] & cellDst[0];
  for (genvar c = 0; c < WIDTH; c++) begin : g_out
    assign doneTag[c] = cellTag[0][c];
    assign wakeTag[c] = cellTag[0][c];
  end

  AST_WAKE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (wakeValid & ~doneValid) == '0) else $error("wakeup without completion"); // R8

endmodule

// File: rtl/anyop_exec_stage.sv
`timescale 1ns/1ps
module anyop_exec_stage
  import anyop_exec_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int TAG_W     = 6,
  parameter int LAT_SHORT = 1,
  parameter int LAT_MID   = 2,
  parameter int LAT_LONG  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WIDTH-1:0]            issueValid,
  input  logic [WIDTH-1:0][1:0]       issueOp,
  input  logic [WIDTH-1:0][TAG_W-1:0] issueTag,
  input  logic [WIDTH-1:0]            issueDstValid,
  output logic [WIDTH-1:0]            doneValid,
  output logic [WIDTH-1:0][TAG_W-1:0] doneTag,
  output logic [WIDTH-1:0]            wakeValid,
  output logic [WIDTH-1:0][TAG_W-1:0] wakeTag
);

  localparam int MAX_SM = (LAT_SHORT > LAT_MID) ? LAT_SHORT : LAT_MID;
  localparam int DEPTH  = (MAX_SM > LAT_LONG) ? MAX_SM : LAT_LONG;

  cellStrobe_t [DEPTH-1:0][WIDTH-1:0] strobe;
  logic [DEPTH-1:0][WIDTH-1:0]        rowOcc;

  anyop_exec_ctrl #(
    .WIDTH(WIDTH), .LAT_SHORT(LAT_SHORT), .LAT_MID(LAT_MID),
    .LAT_LONG(LAT_LONG), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp),
    .rowOcc(rowOcc), .strobe(strobe)
  );

  anyop_exec_datapath #(
    .WIDTH(WIDTH), .TAG_W(TAG_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .issueTag(issueTag), .issueDstValid(issueDstValid),
    .strobe(strobe), .rowOcc(rowOcc), .doneValid(doneValid), .doneTag(doneTag),
    .wakeValid(wakeValid), .wakeTag(wakeTag)
  );

endmodule

// File: tb/tb_anyop_exec_stage.sv
`timescale 1ns/1ps
module tb_anyop_exec_stage;
  localparam int W = 4, TW = 6, RING = 8, LIVE = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0]         issueValid = '0, issueDstValid = '0;
  logic [W-1:0][1:0]    issueOp = '0;
  logic [W-1:0][TW-1:0] issueTag = '0;
  logic [W-1:0]         doneValid, wakeValid;
  logic [W-1:0][TW-1:0] doneTag, wakeTag;

  anyop_exec_stage #(.WIDTH(W), .TAG_W(TW)) dut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp),
    .issueTag(issueTag), .issueDstValid(issueDstValid), .doneValid(doneValid),
    .doneTag(doneTag), .wakeValid(wakeValid), .wakeTag(wakeTag)
  );

  int nChecks = 0, nFails = 0, cur = 0, liveNext = 0, ignNext = 0;
  logic [63:0] dueMask [RING];
  logic [63:0] dstMask [RING];
  int          dueCnt  [RING];
  int          tagLat  [64];
  logic [31:0] rng = 32'h1234_5677;
  logic [W-1:0]      vv, dd;
  logic [W-1:0][1:0] oo;

  function automatic string reqOfLat(input int lat);
    if (lat == 1) return "R2";
    if (lat == 2) return "R3";
    return "R4";
  endfunction

  task automatic note(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    int s, got, t;
    s   = cur % RING;
    got = 0;
    for (int c = 0; c < W; c++) begin
      if (doneValid[c]) begin
        got++;
        t = int'(doneTag[c]);
        if (t >= LIVE) note(1'b0, "R5/R9", "ignored slot completed, tag", t, -1);
        else if (!dueMask[s][t]) note(1'b0, reqOfLat(tagLat[t]), "completion in wrong cycle, tag", t, -1);
        else begin
          note(1'b1, reqOfLat(tagLat[t]), "completion timing", t, t);
          dueMask[s][t] = 1'b0;
          note((wakeValid[c] == dstMask[s][t]) && (!wakeValid[c] || wakeTag[c] == doneTag[c]),
               "R8", "wakeup of completing tag", int'(wakeValid[c]), int'(dstMask[s][t]));
        end
      end else begin
        note(!wakeValid[c], "R8", "wakeup without completion", int'(wakeValid[c]), 0);
      end
    end
    note(got == dueCnt[s], "R7", "completions this cycle", got, dueCnt[s]);
    note(dueMask[s] == '0, "R6", "instructions missing at due cycle", $countones(dueMask[s]), 0);
    dueMask[s] = '0;
    dstMask[s] = '0;
    dueCnt[s]  = 0;
  endtask

  task automatic step(input logic [W-1:0] v, input logic [W-1:0][1:0] op, input logic [W-1:0] dv);
    int lat, s;
    @(negedge clk);
    checkOutputs();
    for (int i = 0; i < W; i++) begin
      lat = (op[i] == 2'd0) ? 1 : (op[i] == 2'd1) ? 2 : 5;
      s   = (cur + lat) % RING;
      if (v[i] && op[i] != 2'd3 && dueCnt[s] < W) begin
        issueValid[i] = 1'b1;
        issueTag[i]   = TW'(liveNext);
        dueMask[s][liveNext] = 1'b1;
        dstMask[s][liveNext] = dv[i];
        tagLat[liveNext]     = lat;
        dueCnt[s]++;
        liveNext = (liveNext + 1) % LIVE;
      end else begin
        issueValid[i] = v[i] && (op[i] == 2'd3);   // reserved kept valid (R5), over-subscribed demoted
        issueTag[i]   = TW'(LIVE + ignNext);
        ignNext       = (ignNext + 1) % LIVE;
      end
      issueOp[i]       = op[i];
      issueDstValid[i] = dv[i];
    end
    cur++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, '0, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL R6 watchdog expired: actual %0d expected %0d", cur, 3700);
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < RING; r++) begin
      dueMask[r] = '0; dstMask[r] = '0; dueCnt[r] = 0;
    end
    for (int t = 0; t < 64; t++) tagLat[t] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    note(doneValid == '0 && wakeValid == '0, "R1", "outputs during reset", int'(doneValid), 0);
    rst = 1'b0;
    @(negedge clk);
    note(doneValid == '0 && wakeValid == '0, "R1", "outputs after reset", int'(doneValid), 0);

    // Exhaustive sweep over per-slot {invalid, op0, op1, op2, op3}, back to back (R2 R3 R4 R5 R9 R6).
    for (int k = 0; k < 625; k++) begin
      int r;
      r = k;
      for (int i = 0; i < W; i++) begin
        int dig;
        dig   = r % 5;
        r     = r / 5;
        vv[i] = (dig != 0);
        oo[i] = (dig == 0) ? 2'((k >> i) & 3) : 2'(dig - 1);
      end
      dd = W'((k * 7) >> 1);
      step(vv, oo, dd);
    end
    idle(6);

    // Out-of-order convergence: 2 long, then mid, then short, all due together (R7).
    step(4'b0011, {2'd2, 2'd2, 2'd2, 2'd2}, 4'b0101);
    idle(2);
    step(4'b0001, {2'd1, 2'd1, 2'd1, 2'd1}, 4'b0001);
    step(4'b0001, {2'd0, 2'd0, 2'd0, 2'd0}, 4'b0000);
    idle(6);

    // Pseudo-random stream (R6 R7 R8).
    for (int k = 0; k < 3000; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      step(rng[3:0], rng[11:4], rng[15:12]);
    end
    idle(8);

    summary();
    $finish;
  end
endmodule